// File: doc/BRIEF.md
# Dual-Channel FIFO Readiness Status Register

This block gathers the readiness of two UART channels into a single 8-bit read-only status byte, so that a host can learn with one access whether either transmit FIFO has room for a burst and whether either receive FIFO has data waiting. For each channel it compares the transmit free-space count with the programmed transmit trigger level. It also compares the receive fill count with the receive trigger level, and it treats a pending receive timeout as receive readiness.

The status byte shares address 7 with an ordinary per-channel register. It is decoded there only when both channel selects are asserted low together, the readiness-enable bit from the modem-control register is set, and internal loopback is off. In every other case a read falls through to the per-channel register data supplied by the selected channel. A read captures its result into a read-data register, so every read returns one consistent snapshot. The live status byte and the decode flag are also registered every cycle.

Top module: `frdy_status_reg`

## Requirements
- R1: Bit 0 of `rdy_status` is 1 when `tx_free_a` is greater than or equal to `tx_trig_a`, and 0 otherwise. The value is registered and appears one clock after the inputs are sampled. A trigger of 0 always gives 1.
- R2: Bit 1 of `rdy_status` applies the same rule as R1 to channel B (`tx_free_b`, `tx_trig_b`).
- R3: Bit 4 of `rdy_status` is 1 when `rx_fill_a` is greater than or equal to `rx_trig_a`, or when `rx_tmo_a` is 1, and 0 otherwise. It is registered like R1.
- R4: Bit 5 of `rdy_status` applies the same rule as R3 to channel B (`rx_fill_b`, `rx_trig_b`, `rx_tmo_b`).
- R5: Bits 3:2 and 7:6 of `rdy_status` always read 0. So does any byte captured from the status register.
- R6: One clock after sampling, `status_sel` is 1 exactly when `addr` was 3'b111, `csel_n` was 2'b00, `mcr_rdy_en` was 1 and `loop_en` was 0.
- R7: A read (`rd_stb`=1, `wr_stb`=0) while the R6 condition holds loads `rd_data` with the status byte computed from the same cycle's inputs. `rd_data` then holds that value until the next read.
- R8: A read while the R6 condition fails loads `chan_a_rdata` when `csel_n[0]` is 0, otherwise `chan_b_rdata` when `csel_n[1]` is 0. When neither select is low, `rd_data` is left unchanged.
- R9: A cycle with `wr_stb`=1 never changes `rd_data`, even when `rd_stb` is also 1. A write at the status address leaves `rdy_status` governed only by R1 to R5.
- R10: While `rst` is 1, `rdy_status`, `status_sel` and `rd_data` are cleared to 0 at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csel_n | input | 2 | Active-low channel selects, bit 0 channel A, bit 1 channel B |
| addr | input | 3 | Register address |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| mcr_rdy_en | input | 1 | Readiness-register enable from modem-control bit 2 |
| loop_en | input | 1 | Internal loopback active |
| tx_free_a | input | 7 | Channel A transmit FIFO free spaces (0 to 64) |
| tx_free_b | input | 7 | Channel B transmit FIFO free spaces (0 to 64) |
| rx_fill_a | input | 7 | Channel A receive FIFO fill count (0 to 64) |
| rx_fill_b | input | 7 | Channel B receive FIFO fill count (0 to 64) |
| tx_trig_a | input | 6 | Channel A transmit trigger level |
| tx_trig_b | input | 6 | Channel B transmit trigger level |
| rx_trig_a | input | 6 | Channel A receive trigger level |
| rx_trig_b | input | 6 | Channel B receive trigger level |
| rx_tmo_a | input | 1 | Channel A receive timeout pending |
| rx_tmo_b | input | 1 | Channel B receive timeout pending |
| chan_a_rdata | input | 8 | Ordinary register data from channel A at the current address |
| chan_b_rdata | input | 8 | Ordinary register data from channel B at the current address |
| rdy_status | output | 8 | Registered readiness status byte |
| status_sel | output | 1 | Registered flag: the readiness register is decoded at the address |
| rd_data | output | 8 | Read-data register |

## Verification
The assertions assume that every input is stable around the rising clock edge and settles from a defined value once reset ends. They also take counts as at most 64, and they treat simultaneous read and write as a legal cycle in which the write wins. The bench drives all inputs on the falling edge. It draws counts only from 0 to 64 and trigger levels from the full 6-bit range, and it biases the address, selects, enable and loopback toward the decode condition so that both the hit and fall-through paths are exercised often. It includes cycles where read and write strobes coincide.

// File: rtl/frdy_pkg.sv
package frdy_pkg;
  localparam int NCH      = 2;
  localparam int CNT_W    = 7;
  localparam int TRIG_W   = 6;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int TX_BASE  = 0;
  localparam int RX_BASE  = 4;
  localparam logic [ADDR_W-1:0] RDY_ADDR = 3'b111;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_CH_A   = 2'd2,
    SRC_CH_B   = 2'd3
  } rd_src_e;
endpackage

// File: rtl/frdy_chan_eval.sv
module frdy_chan_eval #(
  parameter int CNT_W  = 7,
  parameter int TRIG_W = 6
) (
  input  logic [CNT_W-1:0]  tx_free,
  input  logic [CNT_W-1:0]  rx_fill,
  input  logic [TRIG_W-1:0] tx_trig,
  input  logic [TRIG_W-1:0] rx_trig,
  input  logic              rx_tmo,
  output logic              tx_ok,
  output logic              rx_ok
);
  localparam int PAD = CNT_W - TRIG_W;

  logic [CNT_W-1:0] tx_trig_w;
  logic [CNT_W-1:0] rx_trig_w;

  always_comb begin
    tx_trig_w = {{PAD{1'b0}}, tx_trig};
    rx_trig_w = {{PAD{1'b0}}, rx_trig};
    tx_ok     = (tx_free >= tx_trig_w);
    rx_ok     = (rx_fill >= rx_trig_w) || rx_tmo;
  end
endmodule

// File: rtl/frdy_decode.sv
module frdy_decode
  import frdy_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] HIT_ADDR = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        csel_n,
  input  logic              rdy_en,
  input  logic              loop_en,
  input  logic              rd_stb,
  input  logic              wr_stb,
  output logic              hit,
  output rd_src_e           src
);
  always_comb begin
    hit = (addr == HIT_ADDR) && (csel_n == 2'b00) && rdy_en && !loop_en;
    src = SRC_NONE;
    if (rd_stb && !wr_stb) begin
      if (hit)             src = SRC_STATUS;
      else if (!csel_n[0]) src = SRC_CH_A;
      else if (!csel_n[1]) src = SRC_CH_B;
      else                 src = SRC_NONE;
    end
  end
endmodule

// File: rtl/frdy_status_reg.sv
module frdy_status_reg
  import frdy_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          csel_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd_stb,
  input  logic                wr_stb,
  input  logic                mcr_rdy_en,
  input  logic                loop_en,
  input  logic [CNT_W-1:0]    tx_free_a,
  input  logic [CNT_W-1:0]    tx_free_b,
  input  logic [CNT_W-1:0]    rx_fill_a,
  input  logic [CNT_W-1:0]    rx_fill_b,
  input  logic [TRIG_W-1:0]   tx_trig_a,
  input  logic [TRIG_W-1:0]   tx_trig_b,
  input  logic [TRIG_W-1:0]   rx_trig_a,
  input  logic [TRIG_W-1:0]   rx_trig_b,
  input  logic                rx_tmo_a,
  input  logic                rx_tmo_b,
  input  logic [DATA_W-1:0]   chan_a_rdata,
  input  logic [DATA_W-1:0]   chan_b_rdata,
  output logic [DATA_W-1:0]   rdy_status,
  output logic                status_sel,
  output logic [DATA_W-1:0]   rd_data
);
  logic [CNT_W-1:0]  free_arr [NCH];
  logic [CNT_W-1:0]  fill_arr [NCH];
  logic [TRIG_W-1:0] ttrg_arr [NCH];
  logic [TRIG_W-1:0] rtrg_arr [NCH];
  logic [NCH-1:0]    tmo_vec;
  logic [NCH-1:0]    tx_ok;
  logic [NCH-1:0]    rx_ok;
  logic [DATA_W-1:0] status_next;
  logic              hit;
  rd_src_e           rd_src;

  always_comb begin
    free_arr[0] = tx_free_a;  free_arr[1] = tx_free_b;
    fill_arr[0] = rx_fill_a;  fill_arr[1] = rx_fill_b;
    ttrg_arr[0] = tx_trig_a;  ttrg_arr[1] = tx_trig_b;
    rtrg_arr[0] = rx_trig_a;  rtrg_arr[1] = rx_trig_b;
    tmo_vec     = {rx_tmo_b, rx_tmo_a};
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    frdy_chan_eval #(
      .CNT_W (CNT_W),
      .TRIG_W(TRIG_W)
    ) u_eval (
      .tx_free(free_arr[ch]),
      .rx_fill(fill_arr[ch]),
      .tx_trig(ttrg_arr[ch]),
      .rx_trig(rtrg_arr[ch]),
      .rx_tmo (tmo_vec[ch]),
      .tx_ok  (tx_ok[ch]),
      .rx_ok  (rx_ok[ch])
    );
  end

  always_comb begin
    status_next = '0;
    for (int i = 0; i < NCH; i++) begin
      status_next[TX_BASE+i] = tx_ok[i];
      status_next[RX_BASE+i] = rx_ok[i];
    end
  end

  frdy_decode #(
    .ADDR_W  (ADDR_W),
    .HIT_ADDR(RDY_ADDR)
  ) u_dec (
    .addr   (addr),
    .csel_n (csel_n),
    .rdy_en (mcr_rdy_en),
    .loop_en(loop_en),
    .rd_stb (rd_stb),
    .wr_stb (wr_stb),
    .hit    (hit),
    .src    (rd_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_status <= '0;
      status_sel <= 1'b0;
      rd_data    <= '0;
    end else begin
      rdy_status <= status_next;
      status_sel <= hit;
      case (rd_src)
        SRC_STATUS: rd_data <= status_next;
        SRC_CH_A:   rd_data <= chan_a_rdata;
        SRC_CH_B:   rd_data <= chan_b_rdata;
        default:    rd_data <= rd_data;
      endcase
    end
  end

  // Assertions
  AST_TX_A_SPACE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rdy_status[TX_BASE] == ($past(tx_free_a) >= CNT_W'($past(tx_trig_a)))); // R1
  AST_TX_B_SPACE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rdy_status[TX_BASE+1] == ($past(tx_free_b) >= CNT_W'($past(tx_trig_b)))); // R2
  AST_RX_A_TMO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rx_tmo_a)) |-> rdy_status[RX_BASE]); // R3
  AST_RX_B_TMO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rx_tmo_b)) |-> rdy_status[RX_BASE+1]); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk)
    rdy_status[3:2] == 2'b00 && rdy_status[7:6] == 2'b00); // R5
  AST_SEL_DECODE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> status_sel == ($past(addr) == RDY_ADDR && $past(csel_n) == 2'b00
                                   && $past(mcr_rdy_en) && !$past(loop_en))); // R6
  AST_RD_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && rd_src == SRC_STATUS) |-> rd_data == $past(status_next)); // R7
  AST_WR_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wr_stb) |-> $stable(rd_data)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (rdy_status == '0 && !status_sel && rd_data == '0)); // R10
endmodule

// File: tb/tb_frdy_status_reg.sv
module tb_frdy_status_reg;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] csel_n;
  logic [2:0] addr;
  logic       rd_stb, wr_stb, mcr_rdy_en, loop_en;
  logic [6:0] tx_free_a, tx_free_b, rx_fill_a, rx_fill_b;
  logic [5:0] tx_trig_a, tx_trig_b, rx_trig_a, rx_trig_b;
  logic       rx_tmo_a, rx_tmo_b;
  logic [7:0] chan_a_rdata, chan_b_rdata;
  logic [7:0] rdy_status;
  logic       status_sel;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [7:0] exp_rd;

  always #2.5 clk = ~clk;

  frdy_status_reg dut (
    .clk(clk), .rst(rst), .csel_n(csel_n), .addr(addr), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .mcr_rdy_en(mcr_rdy_en), .loop_en(loop_en),
    .tx_free_a(tx_free_a), .tx_free_b(tx_free_b),
    .rx_fill_a(rx_fill_a), .rx_fill_b(rx_fill_b),
    .tx_trig_a(tx_trig_a), .tx_trig_b(tx_trig_b),
    .rx_trig_a(rx_trig_a), .rx_trig_b(rx_trig_b),
    .rx_tmo_a(rx_tmo_a), .rx_tmo_b(rx_tmo_b),
    .chan_a_rdata(chan_a_rdata), .chan_b_rdata(chan_b_rdata),
    .rdy_status(rdy_status), .status_sel(status_sel), .rd_data(rd_data)
  );

  function automatic logic [7:0] model_status();
    logic [7:0] s = 8'h00;
    s[0] = (int'(tx_free_a) >= int'(tx_trig_a));
    s[1] = (int'(tx_free_b) >= int'(tx_trig_b));
    s[4] = (int'(rx_fill_a) >= int'(rx_trig_a)) || rx_tmo_a;
    s[5] = (int'(rx_fill_b) >= int'(rx_trig_b)) || rx_tmo_b;
    return s;
  endfunction

  function automatic logic model_hit();
    return addr == 3'b111 && csel_n == 2'b00 && mcr_rdy_en && !loop_en;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    csel_n = 2'b11; addr = 3'd0; rd_stb = 0; wr_stb = 0;
    mcr_rdy_en = 0; loop_en = 0;
    tx_free_a = 0; tx_free_b = 0; rx_fill_a = 0; rx_fill_b = 0;
    tx_trig_a = 0; tx_trig_b = 0; rx_trig_a = 0; rx_trig_b = 0;
    rx_tmo_a = 0; rx_tmo_b = 0; chan_a_rdata = 8'h00; chan_b_rdata = 8'h00;
  endtask

  // Apply current inputs for one edge, then compare all outputs.
  task automatic step_and_check();
    logic [7:0] es;
    logic       eh;
    string      rtag;
    es = model_status();
    eh = model_hit();
    rtag = "R8";
    if (wr_stb) rtag = "R9";
    else if (rd_stb) begin
      if (eh) begin exp_rd = es; rtag = "R7"; end
      else if (!csel_n[0]) exp_rd = chan_a_rdata;
      else if (!csel_n[1]) exp_rd = chan_b_rdata;
    end
    @(posedge clk); #1;
    check("R1", {7'd0, rdy_status[0]}, {7'd0, es[0]});
    check("R2", {7'd0, rdy_status[1]}, {7'd0, es[1]});
    check("R3", {7'd0, rdy_status[4]}, {7'd0, es[4]});
    check("R4", {7'd0, rdy_status[5]}, {7'd0, es[5]});
    check("R5", {4'd0, rdy_status[7:6], rdy_status[3:2]}, 8'h00);
    check("R6", {7'd0, status_sel}, {7'd0, eh});
    check(rtag, rd_data, exp_rd);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1729));
    idle_inputs();
    rst = 1;
    tx_free_a = 7'd64; tx_trig_a = 6'd1; rx_tmo_b = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R10", rdy_status, 8'h00);
    check("R10", {7'd0, status_sel}, 8'h00);
    check("R10", rd_data, 8'h00);
    @(negedge clk);
    rst = 0;
    exp_rd = 8'h00;
    idle_inputs();

    // Directed: zero trigger always ready, exact-equal boundaries
    tx_free_a = 0; tx_trig_a = 0; tx_free_b = 7'd62; tx_trig_b = 6'd63;
    rx_fill_a = 7'd64; rx_trig_a = 6'd63; rx_fill_b = 7'd63; rx_trig_b = 6'd63;
    step_and_check();
    tx_free_a = 7'd63; tx_trig_a = 6'd63; tx_free_b = 7'd64; tx_trig_b = 6'd63;
    rx_fill_a = 7'd0; rx_trig_a = 6'd63; rx_tmo_a = 1;
    rx_fill_b = 7'd62; rx_trig_b = 6'd63; rx_tmo_b = 0;
    step_and_check();
    // Directed R7: status read on hit
    addr = 3'b111; csel_n = 2'b00; mcr_rdy_en = 1; loop_en = 0; rd_stb = 1;
    step_and_check();
    // Directed R9: write at status address with read also high
    tx_trig_a = 6'd0; rx_tmo_a = 0; wr_stb = 1;
    step_and_check();
    // Directed R8: loopback blocks decode, channel A data read
    wr_stb = 0; loop_en = 1; chan_a_rdata = 8'hA5; chan_b_rdata = 8'h5A;
    step_and_check();
    // Directed R8: enable off, only channel B selected
    loop_en = 0; mcr_rdy_en = 0; csel_n = 2'b01;
    step_and_check();
    // Directed R8: neither selected, rd_data held
    csel_n = 2'b11; chan_a_rdata = 8'h11; chan_b_rdata = 8'h22;
    step_and_check();
    rd_stb = 0;
    step_and_check();

    // Constrained random
    for (int it = 0; it < 3000; it++) begin
      addr         = ($urandom_range(0, 1) == 1) ? 3'b111 : 3'($urandom_range(0, 7));
      csel_n       = ($urandom_range(0, 1) == 1) ? 2'b00 : 2'($urandom_range(0, 3));
      mcr_rdy_en   = ($urandom_range(0, 3) != 0);
      loop_en      = ($urandom_range(0, 3) == 0);
      rd_stb       = 1'($urandom_range(0, 1));
      wr_stb       = ($urandom_range(0, 3) == 0);
      tx_free_a    = 7'($urandom_range(0, 64));
      tx_free_b    = 7'($urandom_range(0, 64));
      rx_fill_a    = 7'($urandom_range(0, 64));
      rx_fill_b    = 7'($urandom_range(0, 64));
      tx_trig_a    = 6'($urandom_range(0, 63));
      tx_trig_b    = 6'($urandom_range(0, 63));
      rx_trig_a    = 6'($urandom_range(0, 63));
      rx_trig_b    = 6'($urandom_range(0, 63));
      rx_tmo_a     = ($urandom_range(0, 3) == 0);
      rx_tmo_b     = ($urandom_range(0, 3) == 0);
      chan_a_rdata = 8'($urandom_range(0, 255));
      chan_b_rdata = 8'($urandom_range(0, 255));
      step_and_check();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule